// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the register-and-memory half of a small microprogrammed processor. Every clock cycle it takes three 3-bit microoperation fields from the control word. Each field is decoded separately. The selected transfers all happen together on the next rising edge. They act on an 11-bit address register, an 11-bit program counter, a 16-bit data register, a 16-bit accumulator and a 2048-word by 16-bit memory.

The block drives the status bits that a sequencer tests:
- the top bit of the data register, used as the indirect flag;
- the top bit of the accumulator, used as the sign;
- an accumulator-is-zero flag.

It also drives the four opcode bits of the data register, which a sequencer maps to a routine address. A separate test port writes and reads the memory directly, so a program and its data can be preloaded before the fields start running.

Top module: `mc_accum_datapath`

## Requirements
- R1: While `rst_n` is low, `ar_o`, `pc_o`, `dr_o` and `ac_o` are all zero. The memory contents are not reset.
- R2: Field `f1` acts as follows on the next rising edge (operations listed by code):
  - 001: AC becomes AC+DR.
  - 010: AC is cleared.
  - 011: AC is incremented.
  - 100: AC becomes DR.
  - 000: no operation.
- R3: Field `f2` acts as follows on the next rising edge:
  - 001: AC becomes AC−DR.
  - 010: AC becomes AC OR DR.
  - 011: AC becomes AC AND DR.
  - 101: DR becomes AC.
  - 110: DR is incremented.
  - 000: no operation.
- R4: Field `f3` acts as follows on the next rising edge:
  - 001: AC becomes AC XOR DR.
  - 010: AC is complemented.
  - 011: AC shifts left.
  - 100: AC shifts right.
  - 101: PC is incremented.
  - 000 and 111: no operation.
- R5: Address transfers:
  - `f1`=101 loads AR with DR bits 10..0.
  - `f1`=110 loads AR with PC.
  - `f3`=110 loads PC with AR.
  - All three use values from before the edge, so AR and PC can exchange contents in one cycle.
- R6: Memory access:
  - `f1`=111 writes DR into the word at AR.
  - `f2`=100 loads DR from the word at AR, using the AR value and memory contents from before the edge.
  - `tp_we` writes `tp_wdata` at `tp_addr`. If the test port and `f1`=111 write the same word in one cycle, the microoperation write wins.
  - `tp_rdata` shows the word at `tp_addr` combinationally.
- R7: When more than one field writes AC in the same cycle, `f1` wins over `f2`, and `f2` wins over `f3`.
- R8: `f2`=111 loads DR bits 10..0 with PC and leaves DR bits 15..11 unchanged.
- R9: Arithmetic and shifts:
  - Addition, subtraction and increments wrap modulo the register width.
  - Both shifts fill the vacated bit with 0.
- R10: Status and opcode outputs:
  - `ind_bit` is DR bit 15.
  - `sign_bit` is AC bit 15.
  - `ac_zero` is high exactly when AC is zero.
  - `opcode` is DR bits 14..11.
- R11: With all three fields at 000, AR, PC, DR and AC hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the four registers |
| f1 | input | 3 | First microoperation field |
| f2 | input | 3 | Second microoperation field |
| f3 | input | 3 | Third microoperation field |
| tp_we | input | 1 | Test port write enable |
| tp_addr | input | 11 | Test port word address |
| tp_wdata | input | 16 | Test port write data |
| tp_rdata | output | 16 | Memory word at `tp_addr` |
| ar_o | output | 11 | Address register |
| pc_o | output | 11 | Program counter |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ind_bit | output | 1 | Indirect status bit (DR bit 15) |
| sign_bit | output | 1 | Sign status bit (AC bit 15) |
| ac_zero | output | 1 | High when AC is zero |
| opcode | output | 4 | DR bits 14..11 for mapping |

## Verification
The bench goes after the following corner cases:
- **Same-cycle read and write.** A memory read and a memory write at the same address in one cycle must return the old word to DR. A design that used the post-edge value would hand DR the word it just wrote.
- **Priority on the accumulator.** Clear against subtract, and load against shift, show whether `f1` really beats `f2` and `f2` beats `f3`. Wrong priority leaves the subtract or shift result in AC.
- **Wrap-around.** Incrementing AC and DR from all ones must give zero and raise `ac_zero`. A wider intermediate would leak a carry instead.
- **Zero fill.** Shifting 0x8001 both ways exposes a rotate or a sign fill, because the vacated bit would come back as 1.
- **Partial DR load.** The `f2`=111 case is checked with nonzero upper DR bits. A design that zero-filled bits 15..11 would lose the opcode and indirect bit.

// File: rtl/mc_accum_datapath.sv
module mc_accum_datapath #(
  parameter int AW  = 11,
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    f1,
  input  logic [2:0]    f2,
  input  logic [2:0]    f3,
  input  logic          tp_we,
  input  logic [AW-1:0] tp_addr,
  input  logic [DW-1:0] tp_wdata,
  output logic [DW-1:0] tp_rdata,
  output logic [AW-1:0] ar_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] dr_o,
  output logic [DW-1:0] ac_o,
  output logic          ind_bit,
  output logic          sign_bit,
  output logic          ac_zero,
  output logic [OPW-1:0] opcode
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ar, pc, ar_nxt, pc_nxt;
  logic [DW-1:0] dr, ac, dr_nxt, ac_nxt, mem_rd;

  assign mem_rd   = mem[ar];
  assign tp_rdata = mem[tp_addr];

  always_comb begin
    ac_nxt = ac;
    case (f3)
      3'b001:  ac_nxt = ac ^ dr;
      3'b010:  ac_nxt = ~ac;
      3'b011:  ac_nxt = {ac[DW-2:0], 1'b0};
      3'b100:  ac_nxt = {1'b0, ac[DW-1:1]};
      default: ;
    endcase
    case (f2)
      3'b001:  ac_nxt = ac - dr;
      3'b010:  ac_nxt = ac | dr;
      3'b011:  ac_nxt = ac & dr;
      default: ;
    endcase
    case (f1)
      3'b001:  ac_nxt = ac + dr;
      3'b010:  ac_nxt = '0;
      3'b011:  ac_nxt = ac + 1'b1;
      3'b100:  ac_nxt = dr;
      default: ;
    endcase
  end

  always_comb begin
    dr_nxt = dr;
    case (f2)
      3'b100:  dr_nxt = mem_rd;
      3'b101:  dr_nxt = ac;
      3'b110:  dr_nxt = dr + 1'b1;
      3'b111:  dr_nxt = {dr[DW-1:AW], pc};
      default: ;
    endcase
  end

  always_comb begin
    ar_nxt = ar;
    case (f1)
      3'b101:  ar_nxt = dr[AW-1:0];
      3'b110:  ar_nxt = pc;
      default: ;
    endcase
    pc_nxt = pc;
    case (f3)
      3'b101:  pc_nxt = pc + 1'b1;
      3'b110:  pc_nxt = ar;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar <= '0;
      pc <= '0;
      dr <= '0;
      ac <= '0;
    end else begin
      ar <= ar_nxt;
      pc <= pc_nxt;
      dr <= dr_nxt;
      ac <= ac_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (tp_we) mem[tp_addr] <= tp_wdata;
    if (f1 == 3'b111) mem[ar] <= dr;
  end

  assign ar_o     = ar;
  assign pc_o     = pc;
  assign dr_o     = dr;
  assign ac_o     = ac;
  assign ind_bit  = dr[DW-1];
  assign sign_bit = ac[DW-1];
  assign ac_zero  = (ac == '0);
  assign opcode   = dr[AW+OPW-1:AW];
endmodule

// File: rtl/mc_accum_datapath_chk.sv
module mc_accum_datapath_chk #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    f1,
  input logic [2:0]    f2,
  input logic [2:0]    f3,
  input logic [AW-1:0] ar_o,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] dr_o,
  input logic [DW-1:0] ac_o
);
  assert_ar_from_dr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    f1 == 3'b101 |=> ar_o == $past(dr_o[AW-1:0]));

  assert_pc_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f3 == 3'b101 |=> pc_o == AW'($past(pc_o) + 1'b1));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    f1 == 3'b010 |=> ac_o == '0);

  assert_dr_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    f2 == 3'b111 |=> (dr_o[DW-1:AW] == $past(dr_o[DW-1:AW])) && (dr_o[AW-1:0] == $past(pc_o)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (f1 == 3'b000 && f2 == 3'b000 && f3 == 3'b000) |=>
      $stable(ar_o) && $stable(pc_o) && $stable(dr_o) && $stable(ac_o));
endmodule

bind mc_accum_datapath mc_accum_datapath_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .f1(f1), .f2(f2), .f3(f3),
  .ar_o(ar_o), .pc_o(pc_o), .dr_o(dr_o), .ac_o(ac_o)
);

// File: tb/mc_accum_datapath_tb.sv
module mc_accum_datapath_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] f1 = '0, f2 = '0, f3 = '0;
  logic tp_we = 1'b0;
  logic [10:0] tp_addr = '0;
  logic [15:0] tp_wdata = '0;
  logic [15:0] tp_rdata, dr_o, ac_o;
  logic [10:0] ar_o, pc_o;
  logic ind_bit, sign_bit, ac_zero;
  logic [3:0] opcode;

  int errors = 0;
  int checks = 0;

  logic [15:0] m_mem [2048];
  logic [10:0] m_ar = '0, m_pc = '0;
  logic [15:0] m_dr = '0, m_ac = '0;

  always #10 clk = ~clk;

  mc_accum_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .f1(f1), .f2(f2), .f3(f3),
    .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata),
    .ar_o(ar_o), .pc_o(pc_o), .dr_o(dr_o), .ac_o(ac_o),
    .ind_bit(ind_bit), .sign_bit(sign_bit), .ac_zero(ac_zero), .opcode(opcode)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "ar", {5'd0, ar_o}, {5'd0, m_ar});
    chk(tag, "pc", {5'd0, pc_o}, {5'd0, m_pc});
    chk(tag, "dr", dr_o, m_dr);
    chk(tag, "ac", ac_o, m_ac);
    chk({tag, " R10"}, "status", {12'd0, ind_bit, sign_bit, ac_zero, 1'b0},
        {12'd0, m_dr[15], m_ac[15], (m_ac == 16'd0), 1'b0});
    chk({tag, " R10"}, "opcode", {12'd0, opcode}, {12'd0, m_dr[14:11]});
    chk({tag, " R6"}, "tp_rdata", tp_rdata, m_mem[tp_addr]);
  endtask

  // Behavioural reference: later statements override earlier ones (f1 over f2 over f3)
  task automatic model_edge();
    logic [15:0] oac, odr, rd, nac, ndr;
    logic [10:0] oar, opc, nar, npc;
    oac = m_ac; odr = m_dr; oar = m_ar; opc = m_pc; rd = m_mem[m_ar];
    nac = oac; ndr = odr; nar = oar; npc = opc;
    if (f3 == 3'd1) nac = oac ^ odr;
    if (f3 == 3'd2) nac = ~oac;
    if (f3 == 3'd3) nac = 16'((oac * 2) % 65536);
    if (f3 == 3'd4) nac = oac / 2;
    if (f3 == 3'd5) npc = 11'((opc + 1) % 2048);
    if (f3 == 3'd6) npc = oar;
    if (f2 == 3'd1) nac = 16'((oac + 65536 - odr) % 65536);
    if (f2 == 3'd2) nac = oac | odr;
    if (f2 == 3'd3) nac = oac & odr;
    if (f2 == 3'd4) ndr = rd;
    if (f2 == 3'd5) ndr = oac;
    if (f2 == 3'd6) ndr = 16'((odr + 1) % 65536);
    if (f2 == 3'd7) ndr = {odr[15:11], opc};
    if (f1 == 3'd1) nac = 16'((oac + odr) % 65536);
    if (f1 == 3'd2) nac = 16'd0;
    if (f1 == 3'd3) nac = 16'((oac + 1) % 65536);
    if (f1 == 3'd4) nac = odr;
    if (f1 == 3'd5) nar = odr[10:0];
    if (f1 == 3'd6) nar = opc;
    if (tp_we) m_mem[tp_addr] = tp_wdata;
    if (f1 == 3'd7) m_mem[oar] = odr;
    m_ac = nac; m_dr = ndr; m_ar = nar; m_pc = npc;
  endtask

  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c, input string tag);
    f1 = a; f2 = b; f3 = c;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) m_mem[i] = 'x;
    repeat (3) @(negedge clk);
    // R1: registers cleared during reset
    chk("R1", "ar", {5'd0, ar_o}, 16'd0);
    chk("R1", "pc", {5'd0, pc_o}, 16'd0);
    chk("R1", "dr", dr_o, 16'd0);
    chk("R1", "ac", ac_o, 16'd0);
    rst_n = 1'b1;

    // Preload memory through the test port (R6)
    tp_we = 1'b1;
    for (int i = 0; i < 2048; i++) begin
      tp_addr = 11'(i);
      tp_wdata = 16'((i * 40503 + 23130) % 65536);
      if (i == 0) tp_wdata = 16'hFFFF;
      if (i == 1) tp_wdata = 16'h8001;
      step(3'd0, 3'd0, 3'd0, "R11");
    end
    tp_we = 1'b0;
    tp_addr = 11'd1;

    step(3'd0, 3'd4, 3'd0, "R6");  chk("R6", "dr load", dr_o, 16'hFFFF);
    step(3'd4, 3'd0, 3'd0, "R2");  chk("R10", "sign", {15'd0, sign_bit}, 16'd1);
    step(3'd3, 3'd0, 3'd0, "R9");  chk("R9", "ac wrap", ac_o, 16'd0);
    chk("R10", "zero", {15'd0, ac_zero}, 16'd1);
    step(3'd0, 3'd6, 3'd0, "R9");  chk("R9", "dr wrap", dr_o, 16'd0);
    step(3'd0, 3'd0, 3'd5, "R4");  chk("R4", "pc inc", {5'd0, pc_o}, 16'd1);
    step(3'd6, 3'd0, 3'd0, "R5");  chk("R5", "ar=pc", {5'd0, ar_o}, 16'd1);
    step(3'd0, 3'd4, 3'd0, "R6");  chk("R10", "ind", {15'd0, ind_bit}, 16'd1);
    step(3'd4, 3'd0, 3'd0, "R2");
    step(3'd0, 3'd0, 3'd3, "R9");  chk("R9", "shl zero fill", ac_o, 16'h0002);
    step(3'd4, 3'd0, 3'd4, "R7");  chk("R7", "f1 over f3", ac_o, 16'h8001);
    step(3'd0, 3'd0, 3'd4, "R9");  chk("R9", "shr zero fill", ac_o, 16'h4000);
    step(3'd2, 3'd1, 3'd1, "R7");  chk("R7", "clear wins", ac_o, 16'd0);
    step(3'd0, 3'd1, 3'd2, "R7");  chk("R7", "f2 over f3", ac_o, 16'h7FFF);
    step(3'd0, 3'd0, 3'd5, "R4");
    step(3'd0, 3'd0, 3'd5, "R4");
    step(3'd0, 3'd7, 3'd0, "R8");  chk("R8", "dr partial", dr_o, 16'h8003);
    step(3'd7, 3'd4, 3'd0, "R6");  chk("R6", "read old word", dr_o, 16'h8001);
    chk("R6", "written word", tp_rdata, 16'h8003);
    step(3'd0, 3'd0, 3'd7, "R4");
    step(3'd5, 3'd0, 3'd6, "R5");
    step(3'd0, 3'd2, 3'd0, "R3");
    step(3'd0, 3'd3, 3'd0, "R3");
    step(3'd0, 3'd5, 3'd0, "R3");
    step(3'd1, 3'd0, 3'd0, "R2");

    for (int k = 0; k < 600; k++) begin
      tp_we = ($urandom % 8) == 0;
      tp_addr = (k % 3 == 0) ? ar_o : 11'($urandom % 2048);
      tp_wdata = 16'($urandom);
      step(3'($urandom), 3'($urandom), 3'($urandom), "R2 R3 R4 R5 R6 R7");
    end
    tp_we = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule